// File: doc/BRIEF.md
# Mailbox Request and Response Engine

This block is the requesting side of a small shared mailbox aperture of eight 32-bit words. A single start pulse launches either an establish operation or a destroy operation. An establish operation carries four queue base addresses, a 16-bit interrupt vector and a reset flag. A destroy operation carries only the reset flag. The top word of the aperture is the control word. Bit 31 of that word shows that the far side currently owns the mailbox.

After a start pulse, the engine first checks the arguments. It then polls the control word until it owns the aperture, and writes the packed message through a simple register master port. Next it polls again for the answer and validates that answer. It ends with a one-cycle done pulse and a 2-bit result code. Polls are spaced by a programmable number of idle cycles and are capped at a programmable count.

Top module: `mbox_req_engine`

## Requirements
- R1: After an accepted start, the engine reads word 7 and repeats the read until bit 31 reads 0. It issues no write before that.
- R2: An establish operation with any address whose bits 11:0 are nonzero, or with a vector above 16'hFFFF, ends with `err` = 1. It makes no read and no write. The destroy operation performs no argument check.
- R3: Each establish address is reduced to its frame number (address shifted right by 12). Message bytes 0 to 23 hold the low 48 bits of each frame number, little endian and 6 bytes each, in the order `eq`, `cq`, `rq`, `sq`. Word i of the aperture holds bytes 4i to 4i+3, least significant byte first.
- R4: Word 6 bits 15:0 hold the upper 4 frame bits (address bits 63:60) of the four addresses: `eq` in bits 3:0, then `cq`, `rq` and `sq` in the higher nibbles. Word 6 bits 31:16 hold the vector.
- R5: The control word written is: type in bits 2:0 (1 for establish, 2 for destroy), version 0 in bits 5:3, direction 0 in bit 7, and the reset flag in bit 24, with all other bits zero. An establish writes words 0 to 7 in ascending order. A destroy writes only word 7.
- R6: Each polling phase makes at most POLL_LIMIT reads, with POLL_GAP idle cycles between reads. If bit 31 is still set on the last read, the operation ends with `err` = 2.
- R7: During the answer phase, if the reset flag was given and word 7 reads 32'hFFFFFFFF, the operation succeeds (`err` = 0). Without the flag, that value counts as still owned by the far side.
- R8: An answer fails validation and ends with `err` = 3 in any of these cases: its bits 2:0 differ from the request type, its version field (bits 5:3) is nonzero, or bit 7 is not 1.
- R9: An answer that is otherwise valid but has a nonzero status byte (bits 15:8) ends with `err` = 3. An answer with a zero status byte ends with `err` = 0.
- R10: `done` is high for exactly one cycle per operation, and `err` is valid in that cycle. A start received while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when the engine is idle |
| op | input | 1 | 0 = establish, 1 = destroy |
| reset_flag | input | 1 | Reset request carried in the control word |
| eq_addr | input | 64 | Event queue base address |
| cq_addr | input | 64 | Completion queue base address |
| rq_addr | input | 64 | Receive queue base address |
| sq_addr | input | 64 | Send queue base address |
| vector | input | 32 | Interrupt vector; must fit in 16 bits |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 2 | 0 none, 1 invalid argument, 2 timeout, 3 protocol |
| bus_rd | output | 1 | Read request, held until acknowledged |
| bus_wr | output | 1 | Write request, held until acknowledged |
| bus_idx | output | 3 | Aperture word index |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transfer acknowledge |

## Verification
The establish path is driven with addresses whose upper nibbles and low frame bits are all distinct. A swapped queue order, a misplaced nibble or a byte-order slip therefore shows up as a word mismatch. Answers are varied one field at a time: type, version, direction and status. Each variant separates one validation term from the others. The all-ones answer is sent both with and without the reset flag, which separates the success shortcut from ordinary ownership polling. Ownership that never clears is applied in each of the two polling phases. This shows the read cap and the write gating apply separately to each phase.

// File: rtl/mbox_req_engine.sv
module mbox_req_engine #(
  parameter int POLL_GAP   = 50000,
  parameter int POLL_LIMIT = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        op,
  input  logic        reset_flag,
  input  logic [63:0] eq_addr,
  input  logic [63:0] cq_addr,
  input  logic [63:0] rq_addr,
  input  logic [63:0] sq_addr,
  input  logic [31:0] vector,
  output logic        busy,
  output logic        done,
  output logic [1:0]  err,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [2:0]  bus_idx,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack
);
  localparam int PCW = $clog2(POLL_LIMIT + 1);
  localparam int GCW = $clog2(POLL_GAP + 1);
  localparam logic [1:0] E_NONE = 2'd0, E_INVAL = 2'd1, E_TIME = 2'd2, E_PROTO = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_GAP, S_WR} st_t;

  st_t            st;
  logic           op_q, rst_q, resp_ph, done_q;
  logic [1:0]     err_q;
  logic [63:0]    eq_q, cq_q, rq_q, sq_q;
  logic [15:0]    vec_q;
  logic [2:0]     idx;
  logic [PCW-1:0] polls;
  logic [GCW-1:0] gap;

  wire args_ok = (eq_addr[11:0] == 12'd0) && (cq_addr[11:0] == 12'd0) &&
                 (rq_addr[11:0] == 12'd0) && (sq_addr[11:0] == 12'd0) &&
                 (vector[31:16] == 16'd0);

  wire [2:0]   req_type = op_q ? 3'd2 : 3'd1;
  wire [31:0]  hdr = {7'd0, rst_q, 16'd0, 5'd0, req_type};
  wire [255:0] msg = {hdr, vec_q,
                      sq_q[63:60], rq_q[63:60], cq_q[63:60], eq_q[63:60],
                      sq_q[59:12], rq_q[59:12], cq_q[59:12], eq_q[59:12]};

  wire all_ones   = resp_ph && rst_q && (bus_rdata == 32'hFFFF_FFFF);
  wire freed      = !bus_rdata[31];
  wire bad_hdr    = (bus_rdata[2:0] != req_type) || (bus_rdata[5:3] != 3'd0) || !bus_rdata[7];
  wire bad_status = bus_rdata[15:8] != 8'd0;
  wire last_poll  = (polls + 1'b1) == PCW'(POLL_LIMIT);

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign err       = err_q;
  assign bus_rd    = st == S_RD;
  assign bus_wr    = st == S_WR;
  assign bus_idx   = (st == S_WR) ? idx : 3'd7;
  assign bus_wdata = msg[{idx, 5'd0} +: 32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= 1'b0; rst_q <= 1'b0; resp_ph <= 1'b0;
      done_q <= 1'b0; err_q <= E_NONE; idx <= 3'd0; polls <= '0; gap <= '0;
      eq_q <= '0; cq_q <= '0; rq_q <= '0; sq_q <= '0; vec_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q <= op; rst_q <= reset_flag; vec_q <= vector[15:0];
          eq_q <= eq_addr; cq_q <= cq_addr; rq_q <= rq_addr; sq_q <= sq_addr;
          resp_ph <= 1'b0; polls <= '0;
          if (!op && !args_ok) begin
            done_q <= 1'b1; err_q <= E_INVAL;
          end else begin
            st <= S_RD;
          end
        end
        S_RD: if (bus_ack) begin
          polls <= polls + 1'b1;
          if (all_ones) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= E_NONE;
          end else if (freed) begin
            if (!resp_ph) begin
              st <= S_WR; idx <= op_q ? 3'd7 : 3'd0;
            end else begin
              st <= S_IDLE; done_q <= 1'b1;
              err_q <= (bad_hdr || bad_status) ? E_PROTO : E_NONE;
            end
          end else if (last_poll) begin
            st <= S_IDLE; done_q <= 1'b1; err_q <= E_TIME;
          end else begin
            st <= S_GAP; gap <= '0;
          end
        end
        S_GAP: begin
          gap <= gap + 1'b1;
          if (gap == GCW'(POLL_GAP - 1)) st <= S_RD;
        end
        S_WR: if (bus_ack) begin
          if (idx == 3'd7) begin
            st <= S_RD; resp_ph <= 1'b1; polls <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  first_write_after_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(bus_rd && bus_ack && !bus_rdata[31]));

  // R2
  inval_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_INVAL) |-> $past(!busy && start));

  // R6
  timeout_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_TIME) |-> (polls == PCW'(POLL_LIMIT)));

  // R8
  proto_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err == E_PROTO) |-> $past(bus_rd && bus_ack));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable({op_q, rst_q, vec_q, eq_q}));
endmodule

// File: tb/mbox_req_engine_tb.sv
module mbox_req_engine_tb_top;
  localparam int GAP = 3;
  localparam int LIM = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, op = 1'b0, reset_flag = 1'b0;
  logic [63:0] eq_addr = '0, cq_addr = '0, rq_addr = '0, sq_addr = '0;
  logic [31:0] vector = '0;
  logic busy, done, bus_rd, bus_wr;
  logic [1:0] err;
  logic [2:0] bus_idx;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;
  logic bus_ack = 1'b0;

  always #10 clk = ~clk;

  mbox_req_engine #(.POLL_GAP(GAP), .POLL_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .reset_flag(reset_flag),
    .eq_addr(eq_addr), .cq_addr(cq_addr), .rq_addr(rq_addr), .sq_addr(sq_addr),
    .vector(vector), .busy(busy), .done(done), .err(err),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_idx(bus_idx), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack));

  int checks = 0, fails = 0;
  int pre_left, rb_left, rd_cnt;
  bit got_final;
  logic [31:0] resp_val;
  logic [2:0]  wl_idx[$];
  logic [31:0] wl_dat[$];
  logic [31:0] exp_w[8];
  int cyc = 0, done_cnt = 0, pulse_viol = 0, idle_viol = 0;
  bit prev_done = 0;

  // Aperture model: one-cycle acknowledge, scripted ownership of word 7.
  always @(posedge clk) begin
    if ((bus_rd || bus_wr) && !bus_ack) begin
      bus_ack <= 1'b1;
      if (bus_wr) begin
        wl_idx.push_back(bus_idx);
        wl_dat.push_back(bus_wdata);
        if (bus_idx == 3'd7) got_final = 1;
      end else begin
        rd_cnt++;
        if (!got_final) begin
          if (pre_left > 0) begin pre_left--; bus_rdata <= 32'h8000_0000; end
          else bus_rdata <= 32'h0;
        end else begin
          if (rb_left > 0) begin rb_left--; bus_rdata <= 32'h8000_0000; end
          else bus_rdata <= resp_val;
        end
      end
    end else begin
      bus_ack <= 1'b0;
    end
  end

  task automatic report(input string msg);
    $display("%0d/%0d checks passed", checks - fails, checks);
    if (msg.len() > 0) $display("%s", msg);
    $finish;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (done) begin
      done_cnt++;
      if (prev_done) pulse_viol++;
    end
    prev_done = done;
    if (!busy && (bus_rd || bus_wr)) idle_viol++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
      report("");
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic void build(input logic o, input logic rf,
      input logic [63:0] e, c, r, s, input logic [31:0] v);
    logic [7:0] b[32];
    logic [63:0] a[4];
    logic [15:0] nib = 16'd0;
    a[0] = e; a[1] = c; a[2] = r; a[3] = s;
    for (int k = 0; k < 32; k++) b[k] = 8'd0;
    for (int k = 0; k < 4; k++) begin
      logic [63:0] f = a[k] >> 12;
      for (int j = 0; j < 6; j++) b[k*6 + j] = f[8*j +: 8];
      nib = nib | (16'(f[51:48]) << (4*k));
    end
    b[24] = nib[7:0];  b[25] = nib[15:8];
    b[26] = v[7:0];    b[27] = v[15:8];
    b[28] = o ? 8'd2 : 8'd1;
    b[31] = rf ? 8'd1 : 8'd0;
    for (int i = 0; i < 8; i++) exp_w[i] = {b[4*i+3], b[4*i+2], b[4*i+1], b[4*i]};
  endfunction

  task automatic run_op(input string req, input logic o, input logic rf,
      input logic [63:0] e, c, r, s, input logic [31:0] v,
      input int pre, input int rb, input logic [31:0] rv,
      input logic [1:0] exp_err, input int exp_nw, input int exp_rd,
      input bit poke, output int elapsed);
    int d0;
    int n = 0;
    pre_left = pre; rb_left = rb; resp_val = rv; rd_cnt = 0; got_final = 0;
    wl_idx.delete(); wl_dat.delete();
    build(o, rf, e, c, r, s, v);
    d0 = done_cnt;
    op = o; reset_flag = rf; eq_addr = e; cq_addr = c; rq_addr = r; sq_addr = s; vector = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 3) begin
        start = 1'b1; op = ~o; eq_addr = 64'h1234;
      end else begin
        start = 1'b0;
      end
    end
    elapsed = n;
    chk(done, req, "done seen", done, 1);
    chk(err == exp_err, req, "error code", err, exp_err);
    chk(wl_idx.size() == exp_nw, req, "write count", wl_idx.size(), exp_nw);
    if (exp_nw == 8 && wl_idx.size() == 8)
      for (int i = 0; i < 8; i++) begin
        chk(wl_idx[i] == 3'(i), req, $sformatf("word %0d index", i), wl_idx[i], i);
        chk(wl_dat[i] == exp_w[i], req, $sformatf("word %0d data", i), wl_dat[i], exp_w[i]);
      end
    if (exp_nw == 1 && wl_idx.size() == 1) begin
      chk(wl_idx[0] == 3'd7, req, "control index", wl_idx[0], 7);
      chk(wl_dat[0] == exp_w[7], req, "control word", wl_dat[0], exp_w[7]);
    end
    if (exp_rd >= 0) chk(rd_cnt == exp_rd, req, "read count", rd_cnt, exp_rd);
    repeat (GAP + 6) @(negedge clk);
    chk(done_cnt == d0 + 1, req, "single done per op", done_cnt - d0, 1);
    chk(!busy, req, "idle after op", busy, 0);
  endtask

  localparam logic [63:0] A_EQ = 64'hA123_4567_89AB_C000;
  localparam logic [63:0] A_CQ = 64'h5000_0000_0000_1000;
  localparam logic [63:0] A_RQ = 64'h0000_0FFF_FFFF_F000;
  localparam logic [63:0] A_SQ = 64'hF000_0000_DEAD_B000;

  initial begin
    int el;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !bus_rd && !bus_wr, "R10", "reset idle state",
        {busy, done, bus_rd, bus_wr}, 0);

    // R1 R3 R4 R5 R9: establish with two owned polls, one busy answer poll
    run_op("R3", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_BEEF,
           2, 1, 32'h0000_0081, 2'd0, 8, 5, 0, el);
    // R2: misaligned address, oversize vector
    run_op("R2", 0, 0, A_EQ, A_CQ | 64'h10, A_RQ, A_SQ, 32'h0000_0001,
           0, 0, 32'h0000_0081, 2'd1, 0, 0, 0, el);
    run_op("R2", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0001_0000,
           0, 0, 32'h0000_0081, 2'd1, 0, 0, 0, el);
    // R5: destroy with reset flag, only control word written
    run_op("R5", 1, 1, 64'h7, 64'h0, 64'h0, 64'h0, 32'hFFFF_FFFF,
           0, 0, 32'h0100_0082, 2'd0, 1, 2, 0, el);
    // R4: different nibble pattern and vector
    run_op("R4", 0, 1, A_SQ, A_RQ, A_EQ, A_CQ, 32'h0000_8001,
           0, 0, 32'h0100_0081, 2'd0, 8, 2, 0, el);
    // R7: all-ones answer with and without reset flag
    run_op("R7", 0, 1, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_0010,
           1, 0, 32'hFFFF_FFFF, 2'd0, 8, 3, 0, el);
    run_op("R7", 1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0,
           0, 0, 32'hFFFF_FFFF, 2'd2, 1, 1 + LIM, 0, el);
    // R8: version too new, wrong type, wrong direction
    run_op("R8", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0,
           0, 0, 32'h0000_0089, 2'd3, 8, 2, 0, el);
    run_op("R8", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0,
           0, 0, 32'h0000_0082, 2'd3, 8, 2, 0, el);
    run_op("R8", 1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0,
           0, 0, 32'h0000_0002, 2'd3, 1, 2, 0, el);
    // R9: nonzero status
    run_op("R9", 1, 0, 64'h0, 64'h0, 64'h0, 64'h0, 32'h0,
           0, 0, 32'h0000_0582, 2'd3, 1, 2, 0, el);
    // R6: ownership never released, and answer never arrives
    run_op("R6", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0,
           100, 0, 32'h0000_0081, 2'd2, 0, LIM, 0, el);
    chk(el >= (LIM - 1) * GAP, "R6", "poll spacing cycles", el, (LIM - 1) * GAP);
    run_op("R6", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0,
           0, 100, 32'h0000_0081, 2'd2, 8, 1 + LIM, 0, el);
    // R10: start while busy is ignored
    run_op("R10", 0, 0, A_EQ, A_CQ, A_RQ, A_SQ, 32'h0000_0042,
           3, 0, 32'h0000_0081, 2'd0, 8, 5, 1, el);

    chk(pulse_viol == 0, "R10", "done wider than one cycle", pulse_viol, 0);
    chk(idle_viol == 0, "R2", "bus activity while idle", idle_viol, 0);
    report("");
  end
endmodule